// File: doc/BRIEF.md
# Shared Cell Buffer Address Manager

This block is the address controller for a switch whose cells all sit in one common cell memory. Arriving cells from every input come in one at a time on a single time-multiplexed write stream. Each carries the index of its destination output. The block either rejects the cell, or hands out a free memory location for it and appends that location to a linked queue kept for the destination. On the read stream, one output is served per cycle. The block returns the oldest stored location for that output and puts the location back in the free pool.

Each cell is admitted under one of two policies. In the partitioned policy, every output owns an equal slice of the memory and cannot exceed it. In the shared policy, any output may use any free location. A per-output cap limits how much one port can hold. A per-output reserve keeps locations back for ports that are below their guaranteed minimum. The cell payload memory and header parsing sit outside this block.

Top module: `cellbuf_mgr`

## Requirements
- R1: While and right after reset, `free_cnt_o` equals DEPTH, every occupancy field of `occ_o` is zero, and `rd_ok_o` is 0 for every port.
- R2: An accepted cell raises `wr_ok_o` combinationally in its cycle, and `wr_addr_o` is the head of the free pool. After that edge the destination's occupancy is one higher and `free_cnt_o` is one lower, unless a read also happens.
- R3: For each output, reads return locations in the order in which cells for that output were accepted.
- R4: The free pool is first in, first out. After reset it hands out locations 0, 1, 2, ... in order, and locations released by reads are handed out again only after all the locations that were already in the pool.
- R5: Under the partitioned policy (`policy_i` = 0), a cell whose output already holds DEPTH/N cells is dropped: `wr_ok_o` is 0 and no location is consumed.
- R6: Under the shared policy (`policy_i` = 1), a cell whose output already holds CAP cells is dropped, and no location is consumed.
- R7: Under the shared policy, a cell is dropped when the free count is not larger than the sum, over the other outputs, of how far each is below RESV. A cell for a port below its own reserve is still accepted while this condition allows it.
- R8: A read request for an empty output gives `rd_ok_o` = 0 and changes neither the free count nor any occupancy.
- R9: When a write and a read for the same output complete in one cycle, that output's occupancy and the free count are unchanged after the edge. The read returns the old head.
- R10: `rd_ok_o` and `rd_addr_o` are valid combinationally in the cycle of the read request. Occupancy is judged before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 1 | 0 = partitioned, 1 = shared with cap and reserve |
| wr_req_i | input | 1 | A cell arrives in this cycle |
| wr_port_i | input | $clog2(N) | Destination output of the arriving cell |
| wr_ok_o | output | 1 | Cell accepted |
| wr_addr_o | output | $clog2(DEPTH) | Location to write the accepted cell to |
| rd_req_i | input | 1 | An output wants its next cell |
| rd_port_i | input | $clog2(N) | Output being served |
| rd_ok_o | output | 1 | A cell is available for that output |
| rd_addr_o | output | $clog2(DEPTH) | Location to read the cell from |
| occ_o | output | N*$clog2(DEPTH+1) | Per-output occupancy, output p in field p |
| free_cnt_o | output | $clog2(DEPTH+1) | Number of locations in the free pool |

## Verification
The accept flag, the write location, the read flag and the read location all settle in the same cycle as the request. The bench drives each request on the falling edge and checks these four signals one nanosecond later, before the rising edge that commits the request. Occupancy and free count change only at that rising edge. The bench therefore reads them at the next falling edge, after an idle step, so every register value it checks is one edge old.

// File: rtl/cellbuf_pkg.sv
package cellbuf_pkg;
    typedef enum logic {
        POL_PARTITION = 1'b0,
        POL_SHARED    = 1'b1
    } policy_e;
endpackage

// File: rtl/cb_free_pool.sv
module cb_free_pool #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_i,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    output logic [AW-1:0] head_o,
    output logic [CW-1:0] count_o
);
    typedef struct {
        logic [AW-1:0] ring [DEPTH];
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } pool_t;

    pool_t pool_d, pool_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        pool_d = pool_q;
        if (pop_i) pool_d.rd = bump(pool_q.rd);
        if (push_i) begin
            pool_d.ring[pool_q.wr] = push_addr_i;
            pool_d.wr              = bump(pool_q.wr);
        end
        case ({push_i, pop_i})
            2'b10:   pool_d.cnt = pool_q.cnt + CW'(1);
            2'b01:   pool_d.cnt = pool_q.cnt - CW'(1);
            default: pool_d.cnt = pool_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pool_q.ring[i] <= AW'(i);
            pool_q.rd  <= '0;
            pool_q.wr  <= '0;
            pool_q.cnt <= CW'(DEPTH);
        end else begin
            pool_q <= pool_d;
        end
    end

    assign head_o  = pool_q.ring[pool_q.rd];
    assign count_o = pool_q.cnt;
endmodule

// File: rtl/cb_admit.sv
module cb_admit
    import cellbuf_pkg::*;
#(
    parameter int N     = 4,
    parameter int DEPTH = 16,
    parameter int CAP   = 8,
    parameter int RESV  = 2,
    parameter int PW    = $clog2(N),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  policy_e       policy_i,
    input  logic [PW-1:0] port_i,
    input  logic [CW-1:0] occ_i [N],
    input  logic [CW-1:0] free_i,
    output logic          admit_o
);
    localparam int REGION = DEPTH / N;

    logic [CW-1:0] owed;
    logic          part_ok;
    logic          shared_ok;

    always_comb begin
        owed = '0;
        for (int p = 0; p < N; p++) begin
            if (PW'(p) != port_i && occ_i[p] < CW'(RESV))
                owed = owed + (CW'(RESV) - occ_i[p]);
        end
        part_ok   = occ_i[port_i] < CW'(REGION);
        shared_ok = (occ_i[port_i] < CW'(CAP)) && (free_i > owed);
        admit_o   = (policy_i == POL_SHARED) ? shared_ok : part_ok;
    end
endmodule

// File: rtl/cb_queue_links.sv
module cb_queue_links #(
    parameter int N     = 4,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = $clog2(N),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_port_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic          rd_en_i,
    input  logic [PW-1:0] rd_port_i,
    output logic [AW-1:0] rd_head_o,
    output logic [CW-1:0] occ_o [N]
);
    typedef struct {
        logic [AW-1:0] head [N];
        logic [AW-1:0] tail [N];
        logic [CW-1:0] cnt  [N];
        logic [AW-1:0] nxt  [DEPTH];
    } links_t;

    links_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (rd_en_i) begin
            lk_d.head[rd_port_i] = lk_q.nxt[lk_q.head[rd_port_i]];
            lk_d.cnt[rd_port_i]  = lk_q.cnt[rd_port_i] - CW'(1);
        end
        if (wr_en_i) begin
            if (lk_d.cnt[wr_port_i] == '0)
                lk_d.head[wr_port_i] = wr_addr_i;
            else
                lk_d.nxt[lk_q.tail[wr_port_i]] = wr_addr_i;
            lk_d.tail[wr_port_i] = wr_addr_i;
            lk_d.cnt[wr_port_i]  = lk_d.cnt[wr_port_i] + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < N; p++) begin
                lk_q.head[p] <= '0;
                lk_q.tail[p] <= '0;
                lk_q.cnt[p]  <= '0;
            end
            for (int i = 0; i < DEPTH; i++) lk_q.nxt[i] <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign rd_head_o = lk_q.head[rd_port_i];
    assign occ_o     = lk_q.cnt;
endmodule

// File: rtl/cellbuf_mgr.sv
module cellbuf_mgr
    import cellbuf_pkg::*;
#(
    parameter int N     = 4,
    parameter int DEPTH = 16,
    parameter int CAP   = 8,
    parameter int RESV  = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(N),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            policy_i,
    input  logic            wr_req_i,
    input  logic [PW-1:0]   wr_port_i,
    output logic            wr_ok_o,
    output logic [AW-1:0]   wr_addr_o,
    input  logic            rd_req_i,
    input  logic [PW-1:0]   rd_port_i,
    output logic            rd_ok_o,
    output logic [AW-1:0]   rd_addr_o,
    output logic [N*CW-1:0] occ_o,
    output logic [CW-1:0]   free_cnt_o
);
    logic [CW-1:0] occ [N];
    logic [CW-1:0] free_cnt;
    logic [AW-1:0] pool_head;
    logic [AW-1:0] queue_head;
    logic          admit;
    logic          wr_go;
    logic          rd_go;
    policy_e       policy;

    assign policy = policy_e'(policy_i);
    assign wr_go  = wr_req_i & admit;
    assign rd_go  = rd_req_i & (occ[rd_port_i] != '0);

    cb_admit #(.N(N), .DEPTH(DEPTH), .CAP(CAP), .RESV(RESV), .PW(PW), .CW(CW)) u_admit (
        .policy_i (policy),
        .port_i   (wr_port_i),
        .occ_i    (occ),
        .free_i   (free_cnt),
        .admit_o  (admit)
    );

    cb_free_pool #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_i       (wr_go),
        .push_i      (rd_go),
        .push_addr_i (queue_head),
        .head_o      (pool_head),
        .count_o     (free_cnt)
    );

    cb_queue_links #(.N(N), .DEPTH(DEPTH), .AW(AW), .PW(PW), .CW(CW)) u_links (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_go),
        .wr_port_i (wr_port_i),
        .wr_addr_i (pool_head),
        .rd_en_i   (rd_go),
        .rd_port_i (rd_port_i),
        .rd_head_o (queue_head),
        .occ_o     (occ)
    );

    for (genvar p = 0; p < N; p++) begin : g_occ
        assign occ_o[p*CW +: CW] = occ[p];
    end

    assign wr_ok_o    = wr_go;
    assign wr_addr_o  = pool_head;
    assign rd_ok_o    = rd_go;
    assign rd_addr_o  = queue_head;
    assign free_cnt_o = free_cnt;
endmodule

// File: rtl/cellbuf_mgr_chk.sv
module cellbuf_mgr_chk #(
    parameter int N     = 4,
    parameter int DEPTH = 16,
    parameter int CAP   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(N),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            policy_i,
    input logic            wr_req_i,
    input logic [PW-1:0]   wr_port_i,
    input logic            wr_ok_o,
    input logic            rd_ok_o,
    input logic [PW-1:0]   rd_port_i,
    input logic [N*CW-1:0] occ_o,
    input logic [CW-1:0]   free_cnt_o
);
    localparam int REGION = DEPTH / N;

    logic [CW+PW:0] total;

    always_comb begin
        total = (CW+PW+1)'(free_cnt_o);
        for (int p = 0; p < N; p++) total = total + (CW+PW+1)'(occ_o[p*CW +: CW]);
    end

    function automatic logic [CW-1:0] occ_of(input logic [PW-1:0] p);
        return occ_o[p*CW +: CW];
    endfunction

    AST_LOCATIONS_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
        total == (CW+PW+1)'(DEPTH)); // R4
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> free_cnt_o == $past(free_cnt_o) - CW'($past(wr_ok_o)) + CW'($past(rd_ok_o))); // R2
    AST_PART_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!policy_i && wr_ok_o) |-> occ_of(wr_port_i) < CW'(REGION)); // R5
    AST_SHARED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i && wr_ok_o) |-> occ_of(wr_port_i) < CW'(CAP)); // R6
    AST_DROP_NO_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !wr_ok_o && !rd_ok_o) |=> $stable(free_cnt_o)); // R7
    AST_SAME_PORT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok_o && rd_ok_o && wr_port_i == rd_port_i) |=> $stable(occ_o)); // R9
endmodule

bind cellbuf_mgr cellbuf_mgr_chk #(.N(N), .DEPTH(DEPTH), .CAP(CAP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .policy_i   (policy_i),
    .wr_req_i   (wr_req_i),
    .wr_port_i  (wr_port_i),
    .wr_ok_o    (wr_ok_o),
    .rd_ok_o    (rd_ok_o),
    .rd_port_i  (rd_port_i),
    .occ_o      (occ_o),
    .free_cnt_o (free_cnt_o)
);

// File: tb/test_cellbuf_mgr.sv
module test_cellbuf_mgr;
    localparam int N = 4, DEPTH = 16, CW = 5;

    logic clk = 1'b0, rst_n = 1'b0, policy = 1'b1;
    logic wr_req = 1'b0, rd_req = 1'b0;
    logic [1:0] wr_port = '0, rd_port = '0;
    logic wr_ok, rd_ok;
    logic [3:0] wr_addr, rd_addr;
    logic [N*CW-1:0] occ;
    logic [CW-1:0] free_cnt;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    cellbuf_mgr i_cellbuf_mgr (
        .clk(clk), .rst_n(rst_n), .policy_i(policy),
        .wr_req_i(wr_req), .wr_port_i(wr_port), .wr_ok_o(wr_ok), .wr_addr_o(wr_addr),
        .rd_req_i(rd_req), .rd_port_i(rd_port), .rd_ok_o(rd_ok), .rd_addr_o(rd_addr),
        .occ_o(occ), .free_cnt_o(free_cnt)
    );

    typedef struct packed {
        logic       wr; logic [1:0] wp;
        logic       rd; logic [1:0] rp;
        logic       ewr; logic [3:0] ewa;
        logic       erd; logic [3:0] era;
    } vec_t;

    // shared policy from reset; R2/R3/R4/R8/R9/R10
    localparam vec_t VEC [10] = '{
        '{1'b1, 2'd0, 1'b0, 2'd0, 1'b1, 4'd0, 1'b0, 4'd0},
        '{1'b1, 2'd1, 1'b0, 2'd0, 1'b1, 4'd1, 1'b0, 4'd0},
        '{1'b1, 2'd0, 1'b0, 2'd0, 1'b1, 4'd2, 1'b0, 4'd0},
        '{1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 4'd0, 1'b1, 4'd0},
        '{1'b1, 2'd2, 1'b1, 2'd2, 1'b1, 4'd3, 1'b0, 4'd0},
        '{1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 4'd4, 1'b1, 4'd2},
        '{1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 4'd0, 1'b1, 4'd4},
        '{1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 4'd0, 1'b0, 4'd0},
        '{1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd0, 1'b1, 4'd1},
        '{1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 4'd0, 1'b1, 4'd3}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [1:0] wp, input logic r, input logic [1:0] rp);
        @(negedge clk);
        wr_req = w; wr_port = wp; rd_req = r; rd_port = rp;
        #1;
    endtask

    function automatic int occ_of(input int p);
        return int'(occ[p*CW +: CW]);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(1'b0, 2'd0, 1'b1, 2'd0);
        step(1'b0, 2'd0, 1'b1, 2'd0);
        check("R1 free", int'(free_cnt), DEPTH);
        check("R1 occ", int'(occ), 0);
        check("R1 rd_ok", int'(rd_ok), 0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            step(VEC[i].wr, VEC[i].wp, VEC[i].rd, VEC[i].rp);
            check("R2/R5-R7 wr_ok", int'(wr_ok), int'(VEC[i].ewr));
            if (VEC[i].ewr) check("R4 wr_addr", int'(wr_addr), int'(VEC[i].ewa));
            check("R8/R10 rd_ok", int'(rd_ok), int'(VEC[i].erd));
            if (VEC[i].erd) check("R3 rd_addr", int'(rd_addr), int'(VEC[i].era));
        end
        step(1'b0, 2'd0, 1'b0, 2'd0);
        check("R4 all returned", int'(free_cnt), DEPTH);

        // R6: shared cap of 8 for output 0; pool order now 5..15,0,2,4,1,3
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 2'd0, 1'b0, 2'd0);
            check("R6 under cap", int'(wr_ok), 1);
            check("R4 pool order", int'(wr_addr), 5 + k);
        end
        step(1'b1, 2'd0, 1'b0, 2'd0);
        check("R6 at cap drop", int'(wr_ok), 0);
        step(1'b0, 2'd0, 1'b0, 2'd0);
        check("R6 no consume", int'(free_cnt), 8);
        check("R6 occ", occ_of(0), 8);

        // R7: output 1 may use space until reserves of 2 and 3 remain
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 2'd1, 1'b0, 2'd0);
            check("R7 accepted", int'(wr_ok), 1);
            check("R4 wrap order", int'(wr_addr), (k == 3) ? 0 : 13 + k);
        end
        step(1'b1, 2'd1, 1'b0, 2'd0);
        check("R7 reserve drop", int'(wr_ok), 0);
        step(1'b1, 2'd2, 1'b0, 2'd0);
        check("R7 own reserve", int'(wr_ok), 1);
        check("R7 addr", int'(wr_addr), 2);
        step(1'b0, 2'd0, 1'b0, 2'd0);
        check("R7 free", int'(free_cnt), 3);

        // R1 again, then partitioned policy
        @(negedge clk); rst_n = 1'b0; policy = 1'b0;
        step(1'b0, 2'd0, 1'b1, 2'd1);
        check("R1 free after reset", int'(free_cnt), DEPTH);
        check("R1 occ after reset", int'(occ), 0);
        check("R1 rd_ok after reset", int'(rd_ok), 0);
        @(negedge clk); rst_n = 1'b1;

        for (int k = 0; k < 4; k++) begin
            step(1'b1, 2'd3, 1'b0, 2'd0);
            check("R5 within region", int'(wr_ok), 1);
            check("R4 fresh order", int'(wr_addr), k);
        end
        step(1'b1, 2'd3, 1'b0, 2'd0);
        check("R5 region full drop", int'(wr_ok), 0);
        step(1'b0, 2'd0, 1'b0, 2'd0);
        check("R5 no consume", int'(free_cnt), 12);

        step(1'b1, 2'd2, 1'b0, 2'd0);
        check("R2 wr_addr", int'(wr_addr), 4);
        step(1'b1, 2'd2, 1'b1, 2'd2);
        check("R9 wr_ok", int'(wr_ok), 1);
        check("R9 wr_addr", int'(wr_addr), 5);
        check("R9 rd_ok", int'(rd_ok), 1);
        check("R9 rd old head", int'(rd_addr), 4);
        step(1'b0, 2'd0, 1'b0, 2'd0);
        check("R9 occ steady", occ_of(2), 1);
        check("R9 free steady", int'(free_cnt), 11);
        step(1'b0, 2'd0, 1'b1, 2'd2);
        check("R3 next in order", int'(rd_addr), 5);
        step(1'b0, 2'd0, 1'b1, 2'd1);
        check("R8 empty read", int'(rd_ok), 0);
        step(1'b0, 2'd0, 1'b0, 2'd0);
        check("R8 free unchanged", int'(free_cnt), 12);
        check("R8 occ unchanged", occ_of(1), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule